// File: doc/BRIEF.md
# DRAM Controller Event Counter Bank

This block is the performance monitoring unit that sits beside a DRAM controller. It has a bank of wide counters. Each counter has its own programmable event code. The code picks one line of an event pulse vector that the controller drives. Code zero is special: it counts every clock cycle. Software reaches the bank through a 32-bit register port. That port has separate read and write strobes and uses word addresses.

Counting has two gates. A global run bit must be set, and the counter's own bit in an enable mask must be set. Software can preload any counter at any time by writing its low or high word. When a counter rolls over from all ones to zero, it latches a pending bit. The single interrupt line is asserted while any pending bit is not blocked by the interrupt mask. Software clears pending bits by writing ones to a dedicated clear word.

Word map, with addresses given as word addresses:
- Counter n: low half at 0x380+2n, high half at 0x381+2n.
- Counter enables: 0x39C.
- Event code of counter n: 0x39D+n.
- Run control: 0x3A8.
- Interrupt mask: 0x14A.
- Pending status: 0x14B.
- Clear: 0x14C.
- Version: 0x1C4.

Top module: `mc_evt_counter_bank`

## Requirements
- R1: After reset, every counter, the run bit, the enable mask and all pending bits are zero. Every interrupt mask bit is one, and irq is low.
- R2: A counter whose event code is 0x00 advances by one on every clock edge at which it is enabled. For example, code 0x00 counts cycles, and codes 0x83 and 0x84 follow write and read data flux on evt_pulse[0x83] and evt_pulse[0x84].
- R3: A counter whose code c lies in 1..0x8F advances by one on each clock edge where evt_pulse[c] is high.
- R4: A counter whose code is 0x90 or above never advances, whatever pulses arrive.
- R5: While bit 0 of the run control word (0x3A8) is clear, no counter advances.
- R6: Bit n of the enable word (0x39C) must be set for counter n to advance.
- R7: Writing the low word loads counter bits 31:0. Writing the high word loads bits 47:32 from wdata[15:0]. Reading the high word returns those 16 bits, zero-extended.
- R8: If a counter word is written on the same edge as an event for that counter, the written value is kept and the event is lost.
- R9: When counter n rolls over from all ones to zero, bit n of the status word (0x14B) becomes 1.
- R10: irq is high exactly while some status bit n is set and mask bit n (0x14A) is 0. A mask bit of 1 blocks that counter's interrupt.
- R11: Writing the clear word (0x14C) clears only the status bits written as 1. A rollover on the same edge keeps its bit set.
- R12: The version word (0x1C4) reads 0x00000002, and writes to it change nothing.
- R13: Read data appears on rd_data on the edge that samples rd_en and then holds. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Word address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| evt_pulse | input | 144 | One line per event code, each a single-cycle pulse |
| irq | output | 1 | Unmasked overflow interrupt |

## Verification
The assertions assume a few things about the inputs. Each evt_pulse line carries at most one pulse per cycle. The strobes and the address only change away from the active edge. A clear written on the same edge as a rollover does not count as a clear of that bit. The stimulus drives every input on the falling edge and holds each pulse for exactly one cycle. It also times the clear-with-rollover case deliberately, so that the set-wins rule is exercised and not merely assumed.

// File: rtl/mcpmu_pkg.sv
// Shared constants for the event counter bank: register word map and ids.
// Assumes a word-addressed 32-bit register port.
package mcpmu_pkg;
    localparam int REG_W      = 32;
    // Word addresses (byte offset / 4)
    localparam int CNT_BASE_A = 'h380;  // counter n low at +2n, high at +2n+1
    localparam int EN_A       = 'h39C;  // per-counter enable mask
    localparam int CODE_BASE_A= 'h39D;  // event code of counter n at +n
    localparam int RUN_A      = 'h3A8;  // bit 0: global run
    localparam int MASK_A     = 'h14A;  // 1 = interrupt blocked
    localparam int STAT_A     = 'h14B;  // pending rollover bits
    localparam int CLR_A      = 'h14C;  // write-one-to-clear
    localparam int VER_A      = 'h1C4;  // read-only identifier
    localparam int CYCLE_CODE = 0;      // code that counts clock cycles
endpackage

// File: rtl/mcpmu_evt_sel.sv
// Event selector: turns a counter's event code into a per-cycle hit.
// Assumes evt_pulse lines are single-cycle pulses; code CYCLE_CODE always
// hits, codes at or above NUM_EVT never hit.
module mcpmu_evt_sel
    import mcpmu_pkg::*;
#(
    parameter int NUM_EVT = 144,
    parameter int CODE_W  = 8
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               hit
);
    // Pick the addressed event line, with the cycle code and range guard.
    always_comb begin
        hit = 1'b0;
        if (int'(code) == CYCLE_CODE)
            hit = 1'b1;
        else
            for (int e = 1; e < NUM_EVT; e++)
                if (int'(code) == e) hit = evt_pulse[e];
    end
endmodule

// File: rtl/mcpmu_counter.sv
// One wide counter with split-word preload and a rollover pulse.
// Assumes CNT_W > REG_W; a write to either half blocks that cycle's increment.
module mcpmu_counter
    import mcpmu_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam int HI_W = CNT_W - REG_W;

    // Preload halves take priority; otherwise advance on an enabled hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt[REG_W-1:0] <= wdata;
            if (wr_hi) cnt[CNT_W-1:REG_W] <= wdata[HI_W-1:0];
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Rollover happens when an all-ones counter takes an increment.
    always_comb wrap = inc && !(wr_lo || wr_hi) && (&cnt);

    // R8: written low half survives a simultaneous event
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt[REG_W-1:0] == $past(wdata));

    // R9: a rollover leaves the counter at zero
    a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == '0);
endmodule

// File: rtl/mcpmu_irq.sv
// Pending-status, mask and interrupt aggregation for the counter bank.
// Assumes wrap bits are single-cycle; a rollover beats a same-cycle clear.
module mcpmu_irq #(
    parameter int NUM_CNT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] wrap,
    input  logic               clr_we,
    input  logic               mask_we,
    input  logic [NUM_CNT-1:0] wbits,
    output logic [NUM_CNT-1:0] status,
    output logic [NUM_CNT-1:0] mask,
    output logic               irq
);
    logic [NUM_CNT-1:0] clr_bits;

    // Bits requested for clearing this cycle.
    always_comb clr_bits = clr_we ? wbits : '0;

    // Pending bits: clear on request, set on rollover (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_bits) | wrap;
    end

    // Mask register, all blocked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_we) mask <= wbits;
    end

    // Interrupt: any pending bit not blocked.
    always_comb irq = |(status & ~mask);

    // R9: every rollover shows up in status on the next cycle
    a_r9_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> (status & $past(wrap)) == $past(wrap));

    // R11: cleared bits drop unless a rollover hit them the same cycle
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (status & $past(wbits & ~wrap)) == '0);

    // R10: fully masked means no interrupt
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);
endmodule

// File: rtl/mc_evt_counter_bank.sv
// Event counter bank top: register decode, per-counter event selection,
// gated counting, and read mux. Assumes single-cycle strobes, one access
// per cycle, and word addresses per mcpmu_pkg.
module mc_evt_counter_bank
    import mcpmu_pkg::*;
#(
    parameter int          NUM_CNT    = 8,
    parameter int          CNT_W      = 48,
    parameter int          NUM_EVT    = 144,
    parameter int          CODE_W     = 8,
    parameter int          ADDR_W     = 10,
    parameter logic [31:0] VERSION_ID = 32'h0000_0002
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq
);
    logic               run_q;
    logic [NUM_CNT-1:0] en_q;
    logic [CODE_W-1:0]  code_q [NUM_CNT];
    logic [CNT_W-1:0]   cnt    [NUM_CNT];
    logic [NUM_CNT-1:0] hit, wrap, wr_lo, wr_hi;
    logic [NUM_CNT-1:0] status, mask;
    logic [REG_W-1:0]   rd_word;

    // Global run bit and enable mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            en_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(RUN_A)) run_q <= wdata[0];
            if (addr == ADDR_W'(EN_A))  en_q  <= wdata[NUM_CNT-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam int LO_A   = CNT_BASE_A + 2*g;
        localparam int CODE_A = CODE_BASE_A + g;

        // Event code register of this counter.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 code_q[g] <= '0;
            else if (wr_en && addr == ADDR_W'(CODE_A))  code_q[g] <= wdata[CODE_W-1:0];
        end

        // Preload strobes for the two halves.
        always_comb begin
            wr_lo[g] = wr_en && addr == ADDR_W'(LO_A);
            wr_hi[g] = wr_en && addr == ADDR_W'(LO_A + 1);
        end

        mcpmu_evt_sel #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_sel (
            .code      (code_q[g]),
            .evt_pulse (evt_pulse),
            .hit       (hit[g])
        );

        mcpmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (run_q && en_q[g] && hit[g]),
            .wr_lo (wr_lo[g]),
            .wr_hi (wr_hi[g]),
            .wdata (wdata),
            .cnt   (cnt[g]),
            .wrap  (wrap[g])
        );

        // R5 and R6: a gated counter without preload holds its value
        a_r5_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q || !en_q[g]) && !wr_lo[g] && !wr_hi[g] |=> $stable(cnt[g]));

        // R4: codes outside the event range never produce a hit
        a_r4_unassigned: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(code_q[g]) >= NUM_EVT) |-> !hit[g]);
    end

    mcpmu_irq #(.NUM_CNT(NUM_CNT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .clr_we  (wr_en && addr == ADDR_W'(CLR_A)),
        .mask_we (wr_en && addr == ADDR_W'(MASK_A)),
        .wbits   (wdata[NUM_CNT-1:0]),
        .status  (status),
        .mask    (mask),
        .irq     (irq)
    );

    // Read mux over every mapped word; unmapped reads give zero.
    always_comb begin
        rd_word = '0;
        if (addr == ADDR_W'(RUN_A))  rd_word = REG_W'(run_q);
        if (addr == ADDR_W'(EN_A))   rd_word = REG_W'(en_q);
        if (addr == ADDR_W'(MASK_A)) rd_word = REG_W'(mask);
        if (addr == ADDR_W'(STAT_A)) rd_word = REG_W'(status);
        if (addr == ADDR_W'(VER_A))  rd_word = VERSION_ID;
        for (int n = 0; n < NUM_CNT; n++) begin
            if (addr == ADDR_W'(CNT_BASE_A + 2*n))     rd_word = cnt[n][REG_W-1:0];
            if (addr == ADDR_W'(CNT_BASE_A + 2*n + 1)) rd_word = REG_W'(cnt[n][CNT_W-1:REG_W]);
            if (addr == ADDR_W'(CODE_BASE_A + n))      rd_word = REG_W'(code_q[n]);
        end
    end

    // Registered read data, captured on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
    end

    // R12: the identifier word always reads back its fixed value
    a_r12_version: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == ADDR_W'(VER_A) |=> rd_data == VERSION_ID);
endmodule

// File: tb/mc_evt_counter_bank_bench.sv
// Directed bench for the event counter bank; one task per scenario.
module mc_evt_counter_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [9:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rd_data;
    logic [143:0] evt = '0;
    logic         irq;
    int           vectors = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_evt_counter_bank u_mc_evt_counter_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .evt_pulse(evt), .irq(irq)
    );

    localparam logic [9:0] RUN = 10'h3A8, EN = 10'h39C, MASK = 10'h14A,
                           STAT = 10'h14B, CLR = 10'h14C, VER = 10'h1C4;
    function automatic logic [9:0] lo_a(int n);   return 10'(10'h380 + 2*n); endfunction
    function automatic logic [9:0] code_a(int n); return 10'(10'h39D + n);   endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic reg_wr(input logic [9:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [9:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input logic [143:0] p);
        evt = p;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd_cnt(input int n, output logic [63:0] v);
        logic [31:0] lo, hi;
        reg_rd(lo_a(n), lo);
        reg_rd(lo_a(n) + 10'd1, hi);
        v = {hi, lo};
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [63:0] v;
        check("R1 irq", irq, 0);
        rd_cnt(0, v);   check("R1 counter0", v, 0);
        reg_rd(RUN, d); check("R1 run", d, 0);
        reg_rd(EN, d);  check("R1 enables", d, 0);
        reg_rd(MASK, d);check("R1 mask", d, 32'hFF);
        reg_rd(STAT, d);check("R1 status", d, 0);
        reg_rd(VER, d); check("R12 version", d, 32'h2);
        reg_wr(VER, 32'hFFFF_FFFF);
        reg_rd(VER, d); check("R12 version after write", d, 32'h2);
        reg_rd(10'h005, d); check("R13 unmapped", d, 0);
    endtask

    task automatic t_cycles();
        logic [63:0] v;
        reg_wr(code_a(0), 32'h0);
        reg_wr(EN, 32'h1);
        reg_wr(RUN, 32'h1);
        repeat (5) @(negedge clk);
        reg_wr(RUN, 32'h0);
        rd_cnt(0, v); check("R2 cycle count", v, 6);
        repeat (4) @(negedge clk);
        pulse('1);
        rd_cnt(0, v); check("R5 run clear holds", v, 6);
    endtask

    task automatic t_events();
        logic [63:0] v;
        reg_wr(code_a(1), 32'h83);
        reg_wr(code_a(2), 32'h84);
        reg_wr(code_a(3), 32'h95);
        reg_wr(code_a(4), 32'h83);
        reg_wr(EN, 32'h0E);
        reg_wr(RUN, 32'h1);
        repeat (3) pulse(144'(1) << 8'h83);
        repeat (2) pulse(144'(1) << 8'h84);
        pulse('1);
        rd_cnt(1, v); check("R3 write flux", v, 4);
        rd_cnt(2, v); check("R3 read flux", v, 3);
        rd_cnt(3, v); check("R4 unassigned code", v, 0);
        rd_cnt(4, v); check("R6 disabled counter", v, 0);
    endtask

    task automatic t_priority();
        logic [63:0] v;
        wr_en = 1'b1; addr = lo_a(1); wdata = 32'h100; evt = 144'(1) << 8'h83;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        rd_cnt(1, v); check("R8 write over event", v, 64'h100);
        pulse(144'(1) << 8'h83);
        rd_cnt(1, v); check("R8 counts after write", v, 64'h101);
    endtask

    task automatic t_preload();
        logic [63:0] v;
        reg_wr(lo_a(5), 32'hDEAD_BEEF);
        reg_wr(lo_a(5) + 10'd1, 32'h1234_ABCD);
        rd_cnt(5, v); check("R7 preload", v, 64'h0000_ABCD_DEAD_BEEF);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        logic [63:0] v;
        reg_wr(code_a(6), 32'h84);
        reg_wr(EN, 32'h40);
        reg_wr(lo_a(6), 32'hFFFF_FFFF);
        reg_wr(lo_a(6) + 10'd1, 32'hFFFF);
        pulse(144'(1) << 8'h84);
        rd_cnt(6, v);    check("R9 wrap to zero", v, 0);
        reg_rd(STAT, d); check("R9 status bit6", d, 32'h40);
        check("R10 masked irq", irq, 0);
        reg_wr(MASK, 32'hBF);
        check("R10 unmasked irq", irq, 1);
        reg_wr(CLR, 32'h01);
        reg_rd(STAT, d); check("R11 other bit clear", d, 32'h40);
        reg_wr(CLR, 32'h40);
        reg_rd(STAT, d); check("R11 clear bit6", d, 0);
        check("R11 irq drops", irq, 0);
        reg_wr(lo_a(6), 32'hFFFF_FFFF);
        reg_wr(lo_a(6) + 10'd1, 32'hFFFF);
        wr_en = 1'b1; addr = CLR; wdata = 32'h40; evt = 144'(1) << 8'h84;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        reg_rd(STAT, d); check("R11 wrap beats clear", d, 32'h40);
        check("R10 irq with wrap", irq, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cycles();
        t_events();
        t_priority();
        t_preload();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule